// File: doc/BRIEF.md
# PHY Control-Register Write Engine

This block is a hardware master that writes single registers in a PHY's internal control-register space. A host asks for a write with a 16-bit internal address, 16-bit data and a one-cycle start strobe. The engine then drives a parallel command word toward the PHY and follows the single acknowledge bit that comes back. It reports busy while it works, a one-cycle done on success, and a timeout error flag when the PHY does not answer.

Every write is made of three handshakes in a fixed order. The first captures the address, the second captures the data, and the third commits the write. Each handshake is four-phase. The value sits on the data field with no command bit for one cycle. The command bit is then added and held until the acknowledge is seen high. The command bit is then removed and the engine waits until the acknowledge is seen low. The acknowledge is sampled once per poll interval of `POLL_CYC` clock cycles, and each wait gives up after `TMO_POLLS` polls. A timeout in any handshake ends the whole write at once, and no later handshake is issued.

The acknowledge input passes through a synchronizer of two flops before the sequencer sees it. The PHY may therefore run on a clock of its own.

Top module: `phy_cfg_writer`

## Requirements
- R1: After reset the command word is all zero, and busy, done and timeout_err are all low. The command word is all zero whenever busy is low.
- R2: Layout of the command word (CMD_W = DATA_W+4). Bits [DATA_W+1:2] carry the value. Bit 0 is the address-capture command and bit 1 is the data-capture command. Bit DATA_W+2 is the read command and is always 0. Bit DATA_W+3 is the write-commit command. At most one command bit is set at any time.
- R3: An accepted write produces this exact series of command-word values: A, A|bit0, A, D, D|bit1, D, D|bit(DATA_W+3), D, then all zero. Here A is the address and D is the data, each placed on the value field.
- R4: A command bit stays set until the synchronized acknowledge has been sampled high at a poll. The next handshake begins only after the acknowledge has been sampled low.
- R5: The acknowledge passes through two flops. A command bit is removed no sooner than three clock edges after the acknowledge rose.
- R6: If a wait does not see the level it expects within TMO_POLLS polls of POLL_CYC cycles, timeout_err rises, busy falls, the command word returns to zero and no later handshake is issued. This applies both to an acknowledge that never rises and to one that never falls.
- R7: done is high for exactly one cycle after a successful commit. timeout_err stays high until the next accepted start, and that start clears it.
- R8: A start strobe while busy is ignored. The address and data of the write in progress do not change.
- R9: busy is high from the cycle after an accepted start until the cycle in which done or timeout_err appears. done and busy are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | One-cycle request to begin a write |
| req_addr | input | DATA_W | Internal register address |
| req_data | input | DATA_W | Value to write |
| busy | output | 1 | A write is in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| timeout_err | output | 1 | Sticky flag: a handshake timed out |
| phy_cmd | output | DATA_W+4 | Command word driven to the PHY |
| phy_ack | input | 1 | Acknowledge from the PHY (asynchronous) |

## Verification
The bench targets the following corner cases:
- Timeouts in each handshake: an acknowledge that never rises in the address, data or commit handshake, and an acknowledge stuck high after the address capture. A design that went on to issue later phases after a timeout would put extra command words on the port. A design with a wrong poll count would flag the error outside the expected cycle window.
- A slow PHY that answers only after ten cycles. This exposes an engine that drops a command bit before the acknowledge is seen, or one that samples the acknowledge without its synchronizer.
- A start strobe with different operands in the middle of a write. A design that accepted it would show the wrong value on the data field.
- Clearing of the error flag by the next start.
- Values of all ones, which expose any misplaced field.

// File: rtl/pcw_pkg.sv
package pcw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_ASSERT  = 2'd2,
    ST_RELEASE = 2'd3
  } pcw_state_e;

  typedef enum logic [1:0] {
    PH_ADDR   = 2'd0,
    PH_DATA   = 2'd1,
    PH_COMMIT = 2'd2
  } pcw_phase_e;

endpackage

// File: rtl/pcw_ack_sync.sv
module pcw_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= async_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/pcw_poll_timer.sv
module pcw_poll_timer #(
  parameter int POLL_CYC  = 200,
  parameter int TMO_POLLS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick,
  output logic last_poll
);

  localparam int CYC_W  = (POLL_CYC  > 1) ? $clog2(POLL_CYC)  : 1;
  localparam int POLL_W = (TMO_POLLS > 1) ? $clog2(TMO_POLLS) : 1;

  logic [CYC_W-1:0]  cyc_q, cyc_n;
  logic [POLL_W-1:0] poll_q, poll_n;

  assign tick      = run && (cyc_q == CYC_W'(POLL_CYC - 1));
  assign last_poll = (poll_q == POLL_W'(TMO_POLLS - 1));

  always_comb begin
    cyc_n  = cyc_q;
    poll_n = poll_q;
    if (clr || !run) begin
      cyc_n  = '0;
      poll_n = '0;
    end else if (tick) begin
      cyc_n  = '0;
      poll_n = last_poll ? poll_q : poll_q + POLL_W'(1);
    end else begin
      cyc_n  = cyc_q + CYC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      poll_q <= '0;
    end else begin
      cyc_q  <= cyc_n;
      poll_q <= poll_n;
    end
  end

  // R6: the poll count never runs past its limit
  assert_poll_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(poll_q) < TMO_POLLS));

endmodule

// File: rtl/pcw_seq.sv
module pcw_seq
  import pcw_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic [DATA_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              ack_s,
  input  logic              tick,
  input  logic              last_poll,
  output logic              tmr_run,
  output logic              tmr_clr,
  output logic [DATA_W+3:0] phy_cmd,
  output logic              busy,
  output logic              done,
  output logic              timeout_err
);

  localparam int CMD_W   = DATA_W + 4;
  localparam int BIT_CA  = 0;
  localparam int BIT_CD  = 1;
  localparam int BIT_WR  = CMD_W - 1;

  pcw_state_e        st_q, st_n;
  pcw_phase_e        ph_q, ph_n;
  logic [DATA_W-1:0] addr_q, data_q;
  logic              done_q, done_n;
  logic              err_q, err_n;
  logic              load_en;
  logic [DATA_W-1:0] value;

  assign value = (ph_q == PH_ADDR) ? addr_q : data_q;

  // Command word
  always_comb begin
    phy_cmd = '0;
    if (st_q != ST_IDLE) begin
      phy_cmd[DATA_W+1:2] = value;
      if (st_q == ST_ASSERT) begin
        case (ph_q)
          PH_ADDR:   phy_cmd[BIT_CA] = 1'b1;
          PH_DATA:   phy_cmd[BIT_CD] = 1'b1;
          PH_COMMIT: phy_cmd[BIT_WR] = 1'b1;
          default:   phy_cmd = '0;
        endcase
      end
    end
  end

  // Next state
  always_comb begin
    st_n    = st_q;
    ph_n    = ph_q;
    done_n  = 1'b0;
    err_n   = err_q;
    load_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_start) begin
          st_n    = ST_SETUP;
          ph_n    = PH_ADDR;
          load_en = 1'b1;
          err_n   = 1'b0;
        end
      end
      ST_SETUP: st_n = ST_ASSERT;
      ST_ASSERT: begin
        if (tick) begin
          if (ack_s) begin
            st_n = ST_RELEASE;
          end else if (last_poll) begin
            st_n  = ST_IDLE;
            err_n = 1'b1;
          end
        end
      end
      ST_RELEASE: begin
        if (tick) begin
          if (!ack_s) begin
            if (ph_q == PH_COMMIT) begin
              st_n   = ST_IDLE;
              done_n = 1'b1;
            end else begin
              st_n = ST_SETUP;
              ph_n = (ph_q == PH_ADDR) ? PH_DATA : PH_COMMIT;
            end
          end else if (last_poll) begin
            st_n  = ST_IDLE;
            err_n = 1'b1;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  assign tmr_run = (st_q == ST_ASSERT) || (st_q == ST_RELEASE);
  assign tmr_clr = (st_n != st_q);

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_ADDR;
      addr_q <= '0;
      data_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      ph_q   <= ph_n;
      done_q <= done_n;
      err_q  <= err_n;
      if (load_en) begin
        addr_q <= req_addr;
        data_q <= req_data;
      end
    end
  end

  assign busy        = (st_q != ST_IDLE);
  assign done        = done_q;
  assign timeout_err = err_q;

  // R1: the port is quiet whenever no write is running
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (phy_cmd == '0));

  // R2: never more than one command bit at a time
  assert_one_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({phy_cmd[BIT_WR], phy_cmd[BIT_CD], phy_cmd[BIT_CA]}));

  // R7: done is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: the error flag holds until a start is accepted
  assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_err && !(req_start && !busy)) |=> timeout_err);

  // R8: a strobe during a write leaves the operands alone
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_start) |=> ($stable(addr_q) && $stable(data_q)));

  // R9: completion and busy never overlap
  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: rtl/phy_cfg_writer.sv
module phy_cfg_writer #(
  parameter int DATA_W      = 16,
  parameter int POLL_CYC    = 200,
  parameter int TMO_POLLS   = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic [DATA_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic              done,
  output logic              timeout_err,
  output logic [DATA_W+3:0] phy_cmd,
  input  logic              phy_ack
);

  localparam int CMD_W = DATA_W + 4;

  logic ack_s;
  logic tick, last_poll;
  logic tmr_run, tmr_clr;
  logic cmd_act;

  pcw_ack_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (phy_ack),
    .sync_out (ack_s)
  );

  pcw_poll_timer #(
    .POLL_CYC  (POLL_CYC),
    .TMO_POLLS (TMO_POLLS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (tmr_run),
    .clr       (tmr_clr),
    .tick      (tick),
    .last_poll (last_poll)
  );

  pcw_seq #(
    .DATA_W (DATA_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_start   (req_start),
    .req_addr    (req_addr),
    .req_data    (req_data),
    .ack_s       (ack_s),
    .tick        (tick),
    .last_poll   (last_poll),
    .tmr_run     (tmr_run),
    .tmr_clr     (tmr_clr),
    .phy_cmd     (phy_cmd),
    .busy        (busy),
    .done        (done),
    .timeout_err (timeout_err)
  );

  assign cmd_act = phy_cmd[0] | phy_cmd[1] | phy_cmd[CMD_W-1];

  // R5: a command bit is removed on an acknowledge seen through the synchronizer
  assert_sync_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cmd_act) && !timeout_err) |-> $past(phy_ack, 3));

  // R4: the command bit is not removed while the acknowledge is low
  assert_hold_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_act && !ack_s && !last_poll) |=> cmd_act);

endmodule

// File: tb/phy_cfg_writer_bench.sv
`timescale 1ns/1ps
module phy_cfg_writer_bench;

  localparam int DW = 16;
  localparam int PC = 3;
  localparam int TP = 6;
  localparam int CW = DW + 4;
  localparam int WB = CW - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_start;
  logic [DW-1:0] req_addr, req_data;
  logic          busy, done, timeout_err;
  logic [CW-1:0] phy_cmd;
  logic          phy_ack;

  always #2.5 clk = ~clk;

  phy_cfg_writer #(
    .DATA_W (DW), .POLL_CYC (PC), .TMO_POLLS (TP), .SYNC_STAGES (2)
  ) u_phy_cfg_writer (
    .clk (clk), .rst_n (rst_n), .req_start (req_start),
    .req_addr (req_addr), .req_data (req_data),
    .busy (busy), .done (done), .timeout_err (timeout_err),
    .phy_cmd (phy_cmd), .phy_ack (phy_ack)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  logic [CW-1:0] exp_cmd_q[$];
  bit            exp_res_q[$];

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Acknowledging slave model
  int slv_block = -1;
  bit slv_stuck = 0;
  int slv_delay = 0;
  int slv_cnt   = 0;

  always @(negedge clk) begin
    logic hit;
    hit = (phy_cmd[0] && slv_block != 0) || (phy_cmd[1] && slv_block != 1) ||
          (phy_cmd[WB] && slv_block != WB);
    if (!rst_n) begin
      phy_ack <= 1'b0;
      slv_cnt = 0;
    end else if (slv_stuck && phy_ack) begin
      phy_ack <= 1'b1;
    end else if (hit) begin
      if (slv_cnt >= slv_delay) phy_ack <= 1'b1;
      slv_cnt++;
    end else begin
      phy_ack <= 1'b0;
      slv_cnt = 0;
    end
  end

  // Monitor: compares command-word changes and outcomes with the scoreboard
  logic [CW-1:0] prev_cmd = '0;
  bit prev_act = 0, prev_done = 0, prev_err = 0;
  int act_cnt = 0, hi_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit act;
      act = phy_cmd[0] | phy_cmd[1] | phy_cmd[WB];
      if (phy_cmd != prev_cmd) begin
        if (exp_cmd_q.size() == 0) begin
          check(1'b0, "R3 unexpected command word", 32'(phy_cmd), 32'(prev_cmd));
        end else begin
          logic [CW-1:0] e;
          e = exp_cmd_q.pop_front();
          check(phy_cmd == e, "R2/R3 command word", 32'(phy_cmd), 32'(e));
        end
      end
      if (act) begin
        act_cnt++;
        if (phy_ack) hi_cnt++;
      end else begin
        if (prev_act && phy_ack) begin
          check(hi_cnt >= 2, "R5 cmd held after ack rise", 32'(hi_cnt), 32'd2);
          check(act_cnt >= slv_delay, "R4 cmd held until ack", 32'(act_cnt), 32'(slv_delay));
        end
        act_cnt = 0;
        hi_cnt  = 0;
      end
      if (done) begin
        if (exp_res_q.size() == 0) check(1'b0, "R7 unexpected done", 32'd1, 32'd0);
        else begin
          bit r;
          r = exp_res_q.pop_front();
          check(r == 1'b0, "R7 done where error expected", 32'd0, 32'(r));
        end
        if (prev_done) check(1'b0, "R7 done longer than one cycle", 32'd2, 32'd1);
        if (busy) check(1'b0, "R9 done with busy", 32'd1, 32'd0);
      end
      if (timeout_err && !prev_err) begin
        if (exp_res_q.size() == 0) check(1'b0, "R6 unexpected timeout", 32'd1, 32'd0);
        else begin
          bit r;
          r = exp_res_q.pop_front();
          check(r == 1'b1, "R6 timeout where success expected", 32'd1, 32'(r));
        end
      end
      prev_cmd  = phy_cmd;
      prev_act  = act;
      prev_done = done;
      prev_err  = timeout_err;
    end
  end

  function automatic logic [CW-1:0] put(input logic [DW-1:0] v);
    return {2'b00, v, 2'b00};
  endfunction

  // Driver: pushes the expected series, then issues the request
  task automatic run_write(input logic [DW-1:0] a, input logic [DW-1:0] d,
                           input int blk, input bit stuck, input int dly,
                           input bit mid_start);
    logic [CW-1:0] av, dv;
    bit exp_err;
    int cyc;
    av = put(a);
    dv = put(d);
    exp_err = 1'b1;
    slv_block = blk; slv_stuck = stuck; slv_delay = dly;
    exp_cmd_q.push_back(av);
    exp_cmd_q.push_back(av | CW'(1));
    if (blk == 0) exp_cmd_q.push_back('0);
    else begin
      exp_cmd_q.push_back(av);
      if (stuck) exp_cmd_q.push_back('0);
      else begin
        exp_cmd_q.push_back(dv);
        exp_cmd_q.push_back(dv | CW'(2));
        if (blk == 1) exp_cmd_q.push_back('0);
        else begin
          exp_cmd_q.push_back(dv);
          exp_cmd_q.push_back(dv | (CW'(1) << WB));
          if (blk == WB) exp_cmd_q.push_back('0);
          else begin
            exp_cmd_q.push_back(dv);
            exp_cmd_q.push_back('0);
            exp_err = 1'b0;
          end
        end
      end
    end
    exp_res_q.push_back(exp_err);

    @(negedge clk);
    req_addr = a; req_data = d; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    cyc = 1;
    check(busy == 1'b1, "R9 busy after start", 32'(busy), 32'd1);
    check(timeout_err == 1'b0, "R7 start clears error", 32'(timeout_err), 32'd0);
    if (mid_start) begin
      repeat (3) @(negedge clk);
      req_addr = ~a; req_data = ~d; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      cyc += 4;
      check(busy == 1'b1, "R8 busy kept after stray start", 32'(busy), 32'd1);
    end
    while (!(done || timeout_err) && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    if (exp_err) begin
      check(timeout_err == 1'b1, "R6 timeout flagged", 32'(timeout_err), 32'd1);
      check(busy == 1'b0, "R6 busy dropped on timeout", 32'(busy), 32'd0);
      if (blk == 0)
        check(cyc >= TP*PC && cyc <= TP*PC + 4, "R6 timeout window",
              32'(cyc), 32'(TP*PC + 2));
      repeat (8) @(negedge clk);
      check(timeout_err == 1'b1, "R7 error held", 32'(timeout_err), 32'd1);
      check(phy_cmd == '0, "R6 no later phase after timeout", 32'(phy_cmd), 32'd0);
    end else begin
      check(done == 1'b1, "R7 done on success", 32'(done), 32'd1);
      check(busy == 1'b0, "R9 busy low at done", 32'(busy), 32'd0);
      @(negedge clk);
      check(done == 1'b0, "R7 done cleared", 32'(done), 32'd0);
    end
    slv_stuck = 0;
    slv_block = -1;
    repeat (4) @(negedge clk);
    check(exp_cmd_q.size() == 0, "R3 all expected words seen",
          32'(exp_cmd_q.size()), 32'd0);
    check(exp_res_q.size() == 0, "R6/R7 outcome seen",
          32'(exp_res_q.size()), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; req_start = 1'b0; req_addr = '0; req_data = '0;
    repeat (4) @(negedge clk);
    check(phy_cmd == '0, "R1 reset command word", 32'(phy_cmd), 32'd0);
    check({busy, done, timeout_err} == 3'b000, "R1 reset flags",
          32'({busy, done, timeout_err}), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(phy_cmd == '0, "R1 idle after reset", 32'(phy_cmd), 32'd0);

    run_write(16'h0015, 16'hA009, -1, 0, 0, 0);   // R3 basic
    run_write(16'h1010, 16'h0080, -1, 0, 10, 0);  // R4 slow slave
    run_write(16'hFFFF, 16'h5555, -1, 0, 0, 0);   // R2 all ones
    run_write(16'h0012, 16'hA000, -1, 0, 3, 1);   // R8 stray start
    run_write(16'h0021, 16'h0042, 0, 0, 0, 0);    // R6 addr timeout
    run_write(16'h0033, 16'h0044, -1, 0, 0, 0);   // R7 clear error
    run_write(16'h0055, 16'h0066, -1, 1, 0, 0);   // R6 stuck ack
    run_write(16'h0077, 16'h0088, 1, 0, 0, 0);    // R6 data timeout
    run_write(16'h0099, 16'h00AA, WB, 0, 0, 0);   // R6 commit timeout
    run_write(16'h8001, 16'h7FFE, -1, 0, 2, 0);   // R3 final

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule